// File: doc/BRIEF.md
# Configuration Space Access Filter

This block sits between a requester and a memory-mapped configuration-space aperture. Each request carries a byte offset into the aperture, a read/write flag and, for writes, a 32-bit data word. The offset is split into four fields: bus number, device number, function number and register byte offset. Only targets that can exist behind the port are passed downstream. These are device 0 on bus 0 and device 0 on bus 1, with any function and any register. Every other target is answered inside the block. A read gets a data word of all ones, and a write is thrown away without any downstream access.

One request is handled at a time. The controller has three states. `ST_IDLE` accepts a request. `ST_FORWARD` holds a downstream access until it is acknowledged. `ST_RESPOND` gives a one-cycle done pulse with the response data. The transitions are:
- idle to forward when an accepted request targets a reachable device;
- idle to respond when an accepted request targets an unreachable one;
- forward to respond on the downstream acknowledge;
- respond back to idle unconditionally.

Top module: `cfg_access_filter`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `dn_valid` and `rsp_done` are 0.
- R2: The address fields are bus = bits 27:20, device = bits 19:15, function = bits 14:12 and register offset = bits 11:0. A forwarded access presents the same 28-bit address, the same write flag and the same write data downstream, in the cycle after acceptance.
- R3: A target is reachable exactly when the bus number is below 2 and the device number is 0. Every function number (0 to 7) and every register offset (0 to 0xFFC) is allowed.
- R4: A read to an unreachable target never raises `dn_valid`. It completes with `rsp_done` in the cycle after acceptance, and `rsp_rdata` is 0xFFFFFFFF.
- R5: A write to an unreachable target never raises `dn_valid`. It completes with `rsp_done` in the cycle after acceptance.
- R6: While `dn_valid` is high and `dn_ack` is low, the next cycle keeps `dn_valid` high with `dn_addr`, `dn_write` and `dn_wdata` unchanged.
- R7: A forwarded access gives `rsp_done` in the cycle after `dn_ack`. For a read, `rsp_rdata` equals the `dn_rdata` seen together with `dn_ack`.
- R8: Every write completion, forwarded or local, returns `rsp_rdata` = 0.
- R9: `req_ready` is low from the cycle after acceptance through the `rsp_done` cycle. Request inputs presented in that window are not taken.
- R10: `rsp_done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken when valid and ready are both high at a clock edge |
| req_addr | input | 28 | Byte offset into the aperture |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |
| dn_valid | output | 1 | Downstream access pending |
| dn_addr | output | 28 | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |

## Verification
Directed accesses sit on both sides of the reachability boundary. Bus 1 against bus 2 and device 0 against device 1 separate a correct bus limit from an off-by-one or a swapped field. Highest function and offset values on a reachable device show that those fields never block.

Random addresses are biased so that about half land on reachable targets. They are mixed with random read/write choices and downstream acknowledge delays from 0 to 6 cycles. This separates correct response timing and data capture from designs that drop late acknowledges or return stale data.

A request held with changed contents during a busy period shows whether the block re-samples or re-accepts while an access is outstanding.

// File: rtl/cfg_filter_pkg.sv
package cfg_filter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FORWARD = 2'd1,
        ST_RESPOND = 2'd2
    } flt_state_e;

endpackage

// File: rtl/cfg_target_decode.sv
module cfg_target_decode #(
    parameter int BUS_W       = 8,
    parameter int DEV_W       = 5,
    parameter int FUNC_W      = 3,
    parameter int OFS_W       = 12,
    parameter int BUS_LIMIT   = 2,
    parameter int DEV_ALLOWED = 0,
    localparam int ADDR_W     = BUS_W + DEV_W + FUNC_W + OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  bus_num,
    output logic [DEV_W-1:0]  dev_num,
    output logic [FUNC_W-1:0] func_num,
    output logic [OFS_W-1:0]  reg_ofs,
    output logic              reachable
);

    localparam int FUNC_LSB = OFS_W;
    localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
    localparam int BUS_LSB  = DEV_LSB + DEV_W;
    localparam logic [BUS_W:0] BUS_LIM_V = (BUS_W+1)'(BUS_LIMIT);
    localparam logic [DEV_W-1:0] DEV_OK_V = DEV_W'(DEV_ALLOWED);

    logic bus_in_range;
    logic dev_match;

    always_comb begin
        bus_num  = addr[BUS_LSB +: BUS_W];
        dev_num  = addr[DEV_LSB +: DEV_W];
        func_num = addr[FUNC_LSB +: FUNC_W];
        reg_ofs  = addr[0 +: OFS_W];
    end

    // Function number and register offset never gate reachability.
    always_comb begin
        bus_in_range = ({1'b0, bus_num} < BUS_LIM_V);
        dev_match    = (dev_num == DEV_OK_V);
        reachable    = bus_in_range && dev_match;
    end

endmodule

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_filter_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              reachable,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              req_ready,
    output logic              dn_valid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ALL_ZERO = {DATA_W{1'b0}};

    flt_state_e        state_q;
    flt_state_e        state_d;
    logic              accept;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_write_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = reachable ? ST_FORWARD : ST_RESPOND;
                end
            end
            ST_FORWARD: begin
                if (dn_ack) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and response data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_q  <= '0;
            lat_write_q <= 1'b0;
            lat_wdata_q <= '0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                lat_addr_q  <= req_addr;
                lat_write_q <= req_write;
                lat_wdata_q <= req_wdata;
                rdata_q     <= (!reachable && !req_write) ? ALL_ONES : ALL_ZERO;
            end else if ((state_q == ST_FORWARD) && dn_ack) begin
                rdata_q     <= lat_write_q ? ALL_ZERO : dn_rdata;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        dn_valid  = 1'b0;
        rsp_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_FORWARD: dn_valid  = 1'b1;
            ST_RESPOND: rsp_done  = 1'b1;
            default:    req_ready = 1'b0;
        endcase
        dn_addr   = lat_addr_q;
        dn_write  = lat_write_q;
        dn_wdata  = lat_wdata_q;
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/cfg_access_filter.sv
module cfg_access_filter #(
    parameter int BUS_W       = 8,
    parameter int DEV_W       = 5,
    parameter int FUNC_W      = 3,
    parameter int OFS_W       = 12,
    parameter int DATA_W      = 32,
    parameter int BUS_LIMIT   = 2,
    parameter int DEV_ALLOWED = 0,
    localparam int ADDR_W     = BUS_W + DEV_W + FUNC_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_valid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata
);

    logic [BUS_W-1:0]  bus_num;
    logic [DEV_W-1:0]  dev_num;
    logic [FUNC_W-1:0] func_num;
    logic [OFS_W-1:0]  reg_ofs;
    logic              reachable;

    cfg_target_decode #(
        .BUS_W      (BUS_W),
        .DEV_W      (DEV_W),
        .FUNC_W     (FUNC_W),
        .OFS_W      (OFS_W),
        .BUS_LIMIT  (BUS_LIMIT),
        .DEV_ALLOWED(DEV_ALLOWED)
    ) u_decode (
        .addr      (req_addr),
        .bus_num   (bus_num),
        .dev_num   (dev_num),
        .func_num  (func_num),
        .reg_ofs   (reg_ofs),
        .reachable (reachable)
    );

    cfg_access_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .reachable (reachable),
        .dn_ack    (dn_ack),
        .dn_rdata  (dn_rdata),
        .req_ready (req_ready),
        .dn_valid  (dn_valid),
        .dn_addr   (dn_addr),
        .dn_write  (dn_write),
        .dn_wdata  (dn_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    // Decoded fields beyond reachability are not consumed downstream.
    logic unused_fields;
    assign unused_fields = ^{func_num, reg_ofs};

endmodule

// File: rtl/cfg_filter_checker.sv
module cfg_filter_checker #(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3,
    parameter int OFS_W  = 12,
    parameter int DATA_W = 32,
    parameter int BUS_LIMIT   = 2,
    parameter int DEV_ALLOWED = 0,
    localparam int ADDR_W = BUS_W + DEV_W + FUNC_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              dn_valid,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              dn_write,
    input logic [DATA_W-1:0] dn_wdata,
    input logic              dn_ack
);

    localparam int DEV_LSB = OFS_W + FUNC_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;

    logic taken;
    logic ok_target;
    assign taken     = req_valid && req_ready;
    assign ok_target = (int'(req_addr[BUS_LSB +: BUS_W]) < BUS_LIMIT) &&
                       (int'(req_addr[DEV_LSB +: DEV_W]) == DEV_ALLOWED);

    AST_FWD_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        taken && ok_target |=> dn_valid && (dn_addr == $past(req_addr))); // R2
    AST_LOCAL_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !ok_target && !req_write |=> rsp_done && !dn_valid && (rsp_rdata == '1)); // R4
    AST_LOCAL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !ok_target && req_write |=> rsp_done && !dn_valid); // R5
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ack |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)); // R6
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ack |=> rsp_done); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid || rsp_done) |-> !req_ready); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10

endmodule

bind cfg_access_filter cfg_filter_checker #(
    .BUS_W (BUS_W), .DEV_W (DEV_W), .FUNC_W (FUNC_W), .OFS_W (OFS_W),
    .DATA_W (DATA_W), .BUS_LIMIT (BUS_LIMIT), .DEV_ALLOWED (DEV_ALLOWED)
) u_chk (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_write (req_write), .rsp_done (rsp_done),
    .rsp_rdata (rsp_rdata), .dn_valid (dn_valid), .dn_addr (dn_addr),
    .dn_write (dn_write), .dn_wdata (dn_wdata), .dn_ack (dn_ack)
);

// File: tb/tb_cfg_access_filter.sv
`timescale 1ns/1ps
module tb_cfg_access_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        dn_valid;
    logic [27:0] dn_addr;
    logic        dn_write;
    logic [31:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_access_filter dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_write (req_write), .req_wdata (req_wdata),
        .rsp_done (rsp_done), .rsp_rdata (rsp_rdata), .dn_valid (dn_valid),
        .dn_addr (dn_addr), .dn_write (dn_write), .dn_wdata (dn_wdata),
        .dn_ack (dn_ack), .dn_rdata (dn_rdata)
    );

    function automatic bit exp_reachable(input logic [27:0] a);
        return (a[27:20] < 8'd2) && (a[19:15] == 5'd0);
    endfunction

    function automatic logic [31:0] model_data(input logic [27:0] a);
        return {a[15:0], a[27:12]} ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One complete access; poke keeps a changed request applied while busy (R9).
    task automatic run_access(input logic [27:0] a, input logic w, input logic [31:0] d,
                              input int ack_delay, input bit poke);
        bit   allowed = exp_reachable(a);
        bit   seen_dn = 1'b0;
        int   cyc = 1;
        int   ack_cyc = -10;
        int   waited = 0;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
        chk(req_ready == 1'b1, "R9 idle ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        if (poke) begin
            req_addr = a ^ 28'h0F0_8000; req_write = ~w; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (cyc < 100) begin
            if (rsp_done) break;
            chk(req_ready == 1'b0, "R9 busy not ready", 32'(req_ready), 32'd0);
            if (dn_valid) begin
                if (!seen_dn) begin
                    chk(allowed, allowed ? "R3 reachable forwarded" : (w ? "R5 dropped write" : "R4 blocked read"),
                        32'(dn_valid), 32'(allowed));
                    chk(cyc == 1, "R2 forward next cycle", 32'(cyc), 32'd1);
                end
                seen_dn = 1'b1;
                chk(dn_addr == a, "R2/R6 dn_addr", 32'(dn_addr), 32'(a));
                chk(dn_write == w, "R6 dn_write", 32'(dn_write), 32'(w));
                if (w) chk(dn_wdata == d, "R6 dn_wdata", dn_wdata, d);
                if (waited == ack_delay) begin
                    dn_ack = 1'b1; dn_rdata = model_data(a); ack_cyc = cyc;
                end else begin
                    waited++;
                end
            end
            @(negedge clk);
            dn_ack = 1'b0; dn_rdata = 32'hDEAD_BEEF;
            cyc++;
        end
        req_valid = 1'b0;
        chk(rsp_done == 1'b1, "R10 done seen", 32'(rsp_done), 32'd1);
        if (allowed) begin
            chk(seen_dn, "R3 reachable forwarded", 32'(seen_dn), 32'd1);
            chk(cyc == ack_cyc + 1, "R7 done after ack", 32'(cyc), 32'(ack_cyc + 1));
            exp_rd = w ? 32'd0 : model_data(a);
            chk(rsp_rdata == exp_rd, w ? "R8 write zero data" : "R7 read data", rsp_rdata, exp_rd);
        end else begin
            chk(!seen_dn, w ? "R5 no downstream write" : "R4 no downstream read", 32'(seen_dn), 32'd0);
            chk(cyc == 1, w ? "R5 local done timing" : "R4 local done timing", 32'(cyc), 32'd1);
            exp_rd = w ? 32'd0 : 32'hFFFF_FFFF;
            chk(rsp_rdata == exp_rd, w ? "R8 write zero data" : "R4 all ones", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R10 single pulse", 32'(rsp_done), 32'd0);
        chk(req_ready == 1'b1 && dn_valid == 1'b0, "R9 back to idle",
            {30'd0, req_ready, dn_valid}, 32'd2);
    endtask

    function automatic logic [27:0] mk(input int bus, input int dev, input int fn, input int ofs);
        return {8'(bus), 5'(dev), 3'(fn), 12'(ofs)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && dn_valid == 1'b0 && rsp_done == 1'b0, "R1 reset state",
            {29'd0, req_ready, dn_valid, rsp_done}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && dn_valid == 1'b0 && rsp_done == 1'b0, "R1 after reset",
            {29'd0, req_ready, dn_valid, rsp_done}, 32'd4);

        // Directed boundaries (R3, R4, R5)
        run_access(mk(0, 0, 0, 0),       1'b0, 32'h0,         0, 1'b0);
        run_access(mk(1, 0, 7, 12'hFFC), 1'b1, 32'h1234_5678, 2, 1'b0);
        run_access(mk(1, 0, 7, 12'hFFC), 1'b0, 32'h0,         3, 1'b0);
        run_access(mk(2, 0, 0, 0),       1'b0, 32'h0,         0, 1'b0);
        run_access(mk(1, 1, 0, 4),       1'b0, 32'h0,         0, 1'b0);
        run_access(mk(0, 16, 0, 8),      1'b1, 32'hAAAA_5555, 0, 1'b0);
        run_access(mk(255, 31, 7, 12'hFFC), 1'b1, 32'hFFFF_0000, 0, 1'b0);
        run_access(mk(0, 0, 3, 12'h100), 1'b0, 32'h0,         6, 1'b1);
        run_access(mk(3, 0, 0, 0),       1'b0, 32'h0,         0, 1'b1);

        // Constrained random mix
        for (int i = 0; i < 200; i++) begin
            logic [27:0] a;
            a = 28'($urandom);
            a[1:0] = 2'b00;
            if ($urandom_range(1, 0) == 1) begin
                a[27:20] = 8'($urandom_range(1, 0));
                a[19:15] = 5'd0;
            end
            run_access(a, 1'($urandom_range(1, 0)), $urandom, $urandom_range(6, 0),
                       ($urandom_range(7, 0) == 0));
        end
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

endmodule